// File: doc/BRIEF.md
# Packet-Command PIO Read Sequencer

This block is the device side of a storage controller's packet command path in programmed-I/O mode. The host writes a byte-count limit, writes the packet opcode 0xA0 to the command register, and then sends a 12-byte command packet as six 16-bit words. If the packet asks for a ten-byte-form block read, the sequencer returns the requested 2048-byte blocks through the data register. The data arrives in bursts. An interrupt announces each burst, and the limit the host programmed sets the largest burst.

The phases show in a status byte: busy (bit 7), ready (bit 6), data request (bit 3) and error (bit 0). Before each burst, the sequencer writes the byte count it will actually deliver into the limit register pair, so the host can read how many bytes to pull. A final interrupt with data request clear closes the command. Block contents come from a computed stub in place of a medium.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x40, the interrupt is low and the limit registers (addresses 4 and 5) read 0.
- R2: Writing 0xA0 to address 7 while idle, with bit 0 of the feature register (address 1) clear, shows status 0xC0 (busy) for one cycle and then 0x48 (ready and data request) for the packet phase.
- R3: The packet is six writes to address 0, each word holding byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Opcode 0x28 in byte 0 is a read. Bytes 2 to 5 hold the big-endian start block and bytes 7 to 8 hold the big-endian block count.
- R4: The limit is address 4 (low byte) and address 5 (high byte). Each burst carries min(remaining bytes, limit with bit 0 cleared). A limit below 2 counts as 0xFFFE.
- R5: Before each burst the burst's byte count is written into addresses 4 and 5. The interrupt is then raised and status reads 0x48. Busy and data request are never set together.
- R6: Word k of the transfer, counting from 0, equals ({F, 8'h00} + (k mod 1024)) mod 2^16. F is the XOR of the four bytes of (start block + k/1024).
- R7: After the last word of the last burst a final interrupt is raised and status reads 0x40.
- R8: Reading address 7 clears the interrupt. If an interrupt is raised in the same cycle, the raise wins.
- R9: A packet opcode other than 0x28 ends with status 0x41, the error register (address 1) reading 0x04, the interrupt raised and no data phase.
- R10: A 0xA0 command with feature bit 0 set is refused at once in the same way as R9, because direct memory transfer is not served.
- R11: A block count of zero ends with the final interrupt and status 0x40 and no data phase.
- R12: Writes to the limit registers while a command is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 16 | Write data (byte registers use bits 7:0) |
| rd_en | input | 1 | Host register read strobe (side effects) |
| rd_addr | input | 3 | Register address of the read |
| rd_data | output | 16 | Read data for rd_addr |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land in the same cycle: a host status read that clears the interrupt, and the sequencer raising the interrupt for the next burst. The bench reads status in the cycle right after the last word of a non-final burst, while the sequencer is sizing the next burst. It expects that read to return 0xC0 (busy) and expects the interrupt to be high afterwards, so the raise has won. A later status read in the data phase must then drop the interrupt.

// File: rtl/atapi_pkg.sv
package atapi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BUSY, ST_PKT, ST_DECODE, ST_PREP, ST_XFER
  } seq_state_t;

  localparam logic [7:0] OP_PACKET = 8'hA0;
  localparam logic [7:0] OP_READ10 = 8'h28;
  localparam logic [7:0] ST_RDY    = 8'h40;
  localparam logic [7:0] ST_BSY    = 8'h80;
  localparam logic [7:0] ST_DRQ    = 8'h08;
  localparam logic [7:0] ST_ERR    = 8'h01;
  localparam logic [7:0] ERR_ABORT = 8'h04;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_FEAT = 3'd1;
  localparam logic [2:0] A_LIML = 3'd4;
  localparam logic [2:0] A_LIMH = 3'd5;
  localparam logic [2:0] A_CMD  = 3'd7;
endpackage

// File: rtl/atapi_pkt_decode.sv
module atapi_pkt_decode #(
  parameter int LBA_W = 32,
  parameter int CNT_W = 16
) (
  input  logic [5:0][15:0]  pkt,
  output logic [7:0]        opcode,
  output logic [LBA_W-1:0]  lba,
  output logic [CNT_W-1:0]  count
);
  logic [95:0] bytes_flat;
  always_comb begin
    for (int i = 0; i < 6; i++) begin
      bytes_flat[16*i +: 8]     = pkt[i][7:0];
      bytes_flat[16*i + 8 +: 8] = pkt[i][15:8];
    end
  end
  // byte n sits at bytes_flat[8n +: 8]; reserved bytes 1, 6, 9..11 unused
  assign opcode = bytes_flat[7:0];
  assign lba    = LBA_W'({bytes_flat[23:16], bytes_flat[31:24],
                          bytes_flat[39:32], bytes_flat[47:40]});
  assign count  = CNT_W'({bytes_flat[63:56], bytes_flat[71:64]});
  logic unused_ok;
  assign unused_ok = ^{bytes_flat[15:8], bytes_flat[55:48], bytes_flat[95:72]};
endmodule

// File: rtl/atapi_burst_calc.sv
module atapi_burst_calc #(
  parameter int REM_W = 27
) (
  input  logic [REM_W-1:0] remain,
  input  logic [15:0]      limit,
  output logic [15:0]      burst
);
  logic [15:0] lim_even;
  assign lim_even = (limit < 16'd2) ? 16'hFFFE : {limit[15:1], 1'b0};
  assign burst = (remain < REM_W'(lim_even)) ? remain[15:0] : lim_even;
endmodule

// File: rtl/atapi_blk_stub.sv
module atapi_blk_stub #(
  parameter int LBA_W = 32,
  parameter int WP_W  = 26,
  parameter int OFF_W = 10
) (
  input  logic [LBA_W-1:0] lba,
  input  logic [WP_W-1:0]  wptr,
  output logic [15:0]      word
);
  logic [LBA_W-1:0] blk;
  logic [7:0]       fold;
  assign blk = lba + LBA_W'(wptr[WP_W-1:OFF_W]);
  always_comb begin
    fold = '0;
    for (int i = 0; i < LBA_W/8; i++) fold = fold ^ blk[8*i +: 8];
  end
  assign word = {fold, 8'h00} + 16'(wptr[OFF_W-1:0]);
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
  import atapi_pkg::*;
#(
  parameter int BLK_BYTES = 2048,
  parameter int CNT_W     = 16,
  parameter int LBA_W     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        irq
);
  localparam int BLK_SH = $clog2(BLK_BYTES);
  localparam int REM_W  = CNT_W + BLK_SH;
  localparam int WP_W   = REM_W - 1;
  localparam int OFF_W  = BLK_SH - 1;

  seq_state_t        state_q, state_d;
  logic              feat_q, feat_d, abort_q, abort_d, irq_q, irq_d;
  logic [15:0]       bcnt_q, bcnt_d, lim_q, lim_d, bwords_q, bwords_d;
  logic [5:0][15:0]  pkt_q, pkt_d;
  logic [2:0]        pidx_q, pidx_d;
  logic [LBA_W-1:0]  lba_q, lba_d, dec_lba;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [WP_W-1:0]   wptr_q, wptr_d;
  logic [7:0]        dec_op, status;
  logic [CNT_W-1:0]  dec_cnt;
  logic [15:0]       burst, word;
  logic [16:0]       burst_w;
  logic              wr_cmd, wr_dat, pop, rd_stat;

  atapi_pkt_decode #(.LBA_W(LBA_W), .CNT_W(CNT_W)) u_dec (
    .pkt(pkt_q), .opcode(dec_op), .lba(dec_lba), .count(dec_cnt));
  atapi_burst_calc #(.REM_W(REM_W)) u_burst (
    .remain(rem_q), .limit(lim_q), .burst(burst));
  atapi_blk_stub #(.LBA_W(LBA_W), .WP_W(WP_W), .OFF_W(OFF_W)) u_stub (
    .lba(lba_q), .wptr(wptr_q), .word(word));

  assign wr_cmd  = wr_en && (wr_addr == A_CMD);
  assign wr_dat  = wr_en && (wr_addr == A_DATA);
  assign pop     = rd_en && (rd_addr == A_DATA) && (state_q == ST_XFER);
  assign rd_stat = rd_en && (rd_addr == A_CMD);
  assign burst_w = {1'b0, burst} + 17'd1;

  always_comb begin
    unique case (state_q)
      ST_IDLE:         status = ST_RDY | (abort_q ? ST_ERR : 8'h00);
      ST_PKT, ST_XFER: status = ST_RDY | ST_DRQ;
      default:         status = ST_RDY | ST_BSY;
    endcase
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_DATA:  rd_data = (state_q == ST_XFER) ? word : 16'h0000;
      A_FEAT:  rd_data = {8'h00, abort_q ? ERR_ABORT : 8'h00};
      A_LIML:  rd_data = {8'h00, bcnt_q[7:0]};
      A_LIMH:  rd_data = {8'h00, bcnt_q[15:8]};
      A_CMD:   rd_data = {8'h00, status};
      default: rd_data = '0;
    endcase
  end

  always_comb begin
    state_d = state_q; feat_d = feat_q; abort_d = abort_q;
    bcnt_d = bcnt_q; lim_d = lim_q; bwords_d = bwords_q;
    pkt_d = pkt_q; pidx_d = pidx_q; lba_d = lba_q;
    rem_d = rem_q; wptr_d = wptr_q;
    irq_d = rd_stat ? 1'b0 : irq_q;   // a raise below overrides the clear
    unique case (state_q)
      ST_IDLE: begin
        if (wr_en && wr_addr == A_FEAT) feat_d = wr_data[0];
        if (wr_en && wr_addr == A_LIML) bcnt_d[7:0]  = wr_data[7:0];
        if (wr_en && wr_addr == A_LIMH) bcnt_d[15:8] = wr_data[7:0];
        if (wr_cmd && wr_data[7:0] == OP_PACKET) begin
          if (feat_q) begin
            abort_d = 1'b1; irq_d = 1'b1;
          end else begin
            abort_d = 1'b0; lim_d = bcnt_q; state_d = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        pidx_d = '0; state_d = ST_PKT;
      end
      ST_PKT: if (wr_dat) begin
        pkt_d[pidx_q] = wr_data;
        pidx_d = pidx_q + 3'd1;
        if (pidx_q == 3'd5) state_d = ST_DECODE;
      end
      ST_DECODE: begin
        wptr_d = '0;
        lba_d  = dec_lba;
        rem_d  = REM_W'(dec_cnt) << BLK_SH;
        if (dec_op != OP_READ10) begin
          abort_d = 1'b1; irq_d = 1'b1; state_d = ST_IDLE;
        end else if (dec_cnt == '0) begin
          irq_d = 1'b1; state_d = ST_IDLE;
        end else begin
          state_d = ST_PREP;
        end
      end
      ST_PREP: begin
        bcnt_d   = burst;
        bwords_d = burst_w[16:1];
        rem_d    = rem_q - REM_W'(burst);
        irq_d    = 1'b1;
        state_d  = ST_XFER;
      end
      ST_XFER: if (pop) begin
        wptr_d   = wptr_q + WP_W'(1);
        bwords_d = bwords_q - 16'd1;
        if (bwords_q == 16'd1) begin
          if (rem_q == '0) begin
            irq_d = 1'b1; state_d = ST_IDLE;
          end else begin
            state_d = ST_PREP;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; feat_q <= 1'b0; abort_q <= 1'b0; irq_q <= 1'b0;
      bcnt_q <= '0; lim_q <= '0; bwords_q <= '0; pkt_q <= '0;
      pidx_q <= '0; lba_q <= '0; rem_q <= '0; wptr_q <= '0;
    end else begin
      state_q <= state_d; feat_q <= feat_d; abort_q <= abort_d; irq_q <= irq_d;
      bcnt_q <= bcnt_d; lim_q <= lim_d; bwords_q <= bwords_d; pkt_q <= pkt_d;
      pidx_q <= pidx_d; lba_q <= lba_d; rem_q <= rem_d; wptr_q <= wptr_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/atapi_seq_chk.sv
module atapi_seq_chk
  import atapi_pkg::*;
#(
  parameter int WP_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input seq_state_t       state_q,
  input logic [7:0]       status,
  input logic [15:0]      bcnt_q,
  input logic [15:0]      lim_q,
  input logic [2:0]       pidx_q,
  input logic [WP_W-1:0]  wptr_q,
  input logic             irq,
  input logic             rd_en,
  input logic [2:0]       rd_addr,
  input logic             wr_en,
  input logic [2:0]       wr_addr
);
  logic [15:0] lim_even;
  assign lim_even = (lim_q < 16'd2) ? 16'hFFFE : {lim_q[15:1], 1'b0};

  AST_NO_BSY_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[3])); // R5
  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER) |-> (bcnt_q <= lim_even && bcnt_q != 16'd0)); // R4
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_CMD && state_q == ST_XFER) |=> !irq); // R8
  AST_PKT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PKT) |-> (pidx_q <= 3'd5)); // R3
  AST_LIMIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && wr_en && (wr_addr == A_LIML || wr_addr == A_LIMH))
    |=> $stable(bcnt_q)); // R12
  AST_IDLE_NO_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> $stable(wptr_q)); // R9
endmodule

bind atapi_pio_seq atapi_seq_chk #(.WP_W(WP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .status(status),
  .bcnt_q(bcnt_q), .lim_q(lim_q), .pidx_q(pidx_q), .wptr_q(wptr_q),
  .irq(irq), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
  .wr_addr(wr_addr));

// File: tb/tb_atapi_pio_seq.sv
module tb_atapi_pio_seq;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, wr_en, rd_en, irq;
  logic [2:0] wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  atapi_pio_seq dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq));

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_en = 1; rd_addr = a;
    #1 d = rd_data;
    @(posedge clk); @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_irq(string req);
    int n = 0;
    while (!irq && n < 200) begin @(negedge clk); n++; end
    check(req, irq, 1);
  endtask

  function automatic logic [15:0] exp_word(logic [31:0] lba, int k);
    logic [31:0] b = lba + 32'(k / 1024);
    logic [7:0] f = b[7:0] ^ b[15:8] ^ b[23:16] ^ b[31:24];
    return {f, 8'h00} + 16'(k % 1024);
  endfunction

  task automatic start_cmd(input logic [15:0] lim, input logic feat);
    logic [15:0] d;
    wr(3'd4, {8'h00, lim[7:0]});
    wr(3'd5, {8'h00, lim[15:8]});
    wr(3'd1, {15'h0, feat});
    wr(3'd7, 16'h00A0);
    if (!feat) begin
      rd(3'd7, d); check("R2 busy after command", d, 8'hC0);
      rd(3'd7, d); check("R2 packet phase", d, 8'h48);
    end
  endtask

  task automatic send_pkt(input logic [7:0] op, input logic [31:0] lba,
                          input logic [15:0] cnt);
    wr(3'd0, {8'h00, op});
    wr(3'd0, {lba[23:16], lba[31:24]});
    wr(3'd0, {lba[7:0], lba[15:8]});
    wr(3'd0, {cnt[15:8], 8'h00});
    wr(3'd0, {8'h00, cnt[7:0]});
    wr(3'd0, 16'h0000);
  endtask

  // collide: read status right after a non-final burst; poke: write limit mid-run
  task automatic run_read(input logic [31:0] lba, input logic [15:0] cnt,
                          input logic [15:0] lim, input bit collide, input bit poke);
    logic [15:0] d, dh;
    int rem = int'(cnt) * 2048;
    int le = (lim < 2) ? 16'hFFFE : (lim & 16'hFFFE);
    int k = 0;
    start_cmd(lim, 0);
    send_pkt(8'h28, lba, cnt);
    while (rem > 0) begin
      int b = (rem < le) ? rem : le;
      int bad = 0;
      wait_irq("R5 burst interrupt");
      rd(3'd4, d); rd(3'd5, dh);
      check("R4 burst byte count", {dh[7:0], d[7:0]}, b);
      if (poke) begin
        wr(3'd4, 16'h0013);
        rd(3'd4, d); check("R12 limit write ignored", d[7:0], b & 8'hFF);
      end
      rd(3'd7, d); check("R5 data phase status", d, 8'h48);
      check("R8 status read clears irq", irq, 0);
      for (int i = 0; i < (b + 1) / 2; i++) begin
        rd(3'd0, d);
        if (d !== exp_word(lba, k) && bad == 0) begin
          bad = 1;
          $display("FAIL R6 word %0d: actual 0x%0h expected 0x%0h", k, d, exp_word(lba, k));
        end
        k++;
      end
      checks++; if (bad) fails++;
      rem -= b;
      if (collide && rem > 0) begin
        collide = 0;
        rd(3'd7, d); check("R8 status while sizing", d, 8'hC0);
        check("R8 raise wins over clear", irq, 1);
      end
    end
    wait_irq("R7 final interrupt");
    rd(3'd7, d); check("R7 final status", d, 8'h40);
    check("R7 irq cleared", irq, 0);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(3'd7, d); check("R1 reset status", d, 8'h40);
    check("R1 reset irq", irq, 0);
    rd(3'd4, d); check("R1 reset limit low", d, 0);
    rd(3'd5, d); check("R1 reset limit high", d, 0);
  endtask

  task automatic t_bad_op;
    logic [15:0] d;
    start_cmd(16'd5120, 0);
    send_pkt(8'h12, 32'd0, 16'd1);
    wait_irq("R9 abort interrupt");
    rd(3'd7, d); check("R9 abort status", d, 8'h41);
    rd(3'd1, d); check("R9 abort code", d, 8'h04);
    rd(3'd0, d); check("R9 no data phase", d, 0);
  endtask

  task automatic t_dma;
    logic [15:0] d;
    start_cmd(16'd5120, 1);
    wait_irq("R10 refused interrupt");
    rd(3'd7, d); check("R10 refused status", d, 8'h41);
    rd(3'd1, d); check("R10 abort code", d, 8'h04);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_zero;
    logic [15:0] d;
    start_cmd(16'd5120, 0);
    send_pkt(8'h28, 32'd7, 16'd0);
    wait_irq("R11 final interrupt");
    rd(3'd7, d); check("R11 status", d, 8'h40);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_read(32'd0, 16'd1, 16'd5120, 0, 0);          // R3 single block
    run_read(32'h0102_03FF, 16'd4, 16'd5121, 0, 0);  // R4 odd limit rounded
    run_read(32'd9, 16'd2, 16'd2048, 1, 1);          // R8 and R12
    run_read(32'd100, 16'd33, 16'd0, 0, 0);          // R4 limit zero
    t_bad_op();
    t_dma();
    t_zero();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule